// File: doc/BRIEF.md
# Serial ADC Device-Side Interface Controller

This block is the digital front end of a 10-bit converter with a serial output. A host drives an active-low select line and a serial clock. The block samples both in its own system clock domain and returns the last finished conversion result one bit per serial clock, MSB first. It also raises a sampling window for the analog side. On the tenth serial clock it starts a conversion engine, which runs for a fixed number of system cycles. When that engine finishes, the block captures the engine's result word as the next value to return. It supports two ways of framing. In the first, select is released between transfers, and each select assertion presents the MSB. In the second, select is held low, and a new frame opens when the conversion finishes. With 16 slow clocks the new frame instead opens after the sixteenth clock falls.

States: `ST_IDLE` (select released, output off), `ST_SHIFT` (result bits going out, counting falling edges 0 to 9), `ST_TAIL` (tenth edge passed, output held low, clocks 11 to 16 counted), `ST_LOST` (late eleventh clock, waiting for select to rise). Transitions:
- IDLE→SHIFT on an accepted select fall.
- SHIFT→TAIL on the tenth falling edge, which also starts the conversion.
- TAIL→SHIFT in two cases: on conversion completion when 10 or 16 edges have been counted, or on the sixteenth edge when no conversion is running.
- TAIL→LOST when the eleventh rising edge comes after the timeout while converting.
- Any state other than IDLE returns to IDLE on an accepted select rise.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, data_oe, sample_en, start_convert, busy and sync_err are all 0, and the stored result is 0.
- R2: While the accepted select level is high, data_oe is 0 and serial clock edges cause no shifting and no conversion.
- R3: When a select fall is accepted, data_out shows bit 9 (MSB) of the last completed result. Each serial falling edge moves down one bit, so bit 0 shows after the ninth falling edge.
- R4: From the tenth falling edge on, data_out is 0 for the rest of the transfer, through the sixteenth clock.
- R5: sample_en is 1 from the third falling edge until the tenth falling edge, and 0 at all other times.
- R6: On the tenth falling edge, start_convert pulses for one cycle and busy rises with it. busy stays high for CONV_CYCLES cycles, and the engine's result word is captured in the last of them. A transfer of fewer than ten clocks starts no conversion.
- R7: Suppose that during a conversion the eleventh rising edge arrives more than TMO_CYCLES cycles after the tenth falling edge. Then sync_err goes to 1 and data_out is held at 0 until a select rise is accepted.
- R8: A new select level is accepted only after it has been stable for CS_STABLE consecutive synchronized cycles. A shorter pulse has no effect.
- R9: With select held low and a 10-clock transfer, finishing the conversion opens a new frame that presents the MSB of the new result.
- R10: With select held low and a 16-clock transfer, a conversion that ends during clocks 11 to 15 leads to a new frame after the sixteenth falling edge. If all 16 clocks end before the conversion does, the new frame opens when the conversion ends.
- R11: An accepted select rise ends any frame and sets data_oe to 0. A running conversion continues to its end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from host (asynchronous) |
| io_clk | input | 1 | Serial clock from host (asynchronous) |
| conv_result | input | W | Word from the conversion engine, captured at end of conversion |
| data_out | output | 1 | Serial result bit |
| data_oe | output | 1 | Output enable for the tri-state data pad |
| sample_en | output | 1 | Analog sampling window |
| start_convert | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | Conversion in progress |
| sync_err | output | 1 | Loss of serial synchronization |

## Verification
The bench compares the block against a behavioural reference model on every cycle. It drives the following input patterns:
- Select toggled between 10-clock and 16-clock transfers. These show that bits come from the previous conversion and not the current one.
- Held-select 10-clock transfers and fast 16-clock transfers. These tell apart "new frame at completion" and "new frame after edge 16".
- Slow 16-clock transfers, where the clock stretches past the end of the conversion.
- Select clocked while high, select glitches shorter than the filter time, and a truncated 7-clock transfer. These show that nothing is started or shifted.
- A late eleventh clock, which separates a valid 10-clock transfer from a loss of synchronization.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_LOST  = 2'd3
    } fe_state_t;
endpackage

// File: rtl/adc_if_sync.sv
module adc_if_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_if_csfilt.sv
module adc_if_csfilt #(
    parameter int STABLE = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    output logic cs_acc,
    output logic acc_fall,
    output logic acc_rise
);
    localparam int CW = $clog2(STABLE + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STABLE - 1);

    logic [CW-1:0] run;
    logic          flip;

    assign flip     = (cs_s != cs_acc) && (run == LIMIT);
    assign acc_fall = flip && cs_acc;
    assign acc_rise = flip && !cs_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_acc <= 1'b1;
            run    <= '0;
        end else if (cs_s == cs_acc) begin
            run <= '0;
        end else if (flip) begin
            cs_acc <= cs_s;
            run    <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/adc_if_conv.sv
module adc_if_conv #(
    parameter int W           = 10,
    parameter int CONV_CYCLES = 1050
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] result_in,
    output logic         busy,
    output logic         done,
    output logic         start_q,
    output logic [W-1:0] result_q
);
    localparam int CTW = $clog2(CONV_CYCLES + 1);
    localparam logic [CTW-1:0] LOAD = CTW'(CONV_CYCLES);

    logic [CTW-1:0] left;

    assign busy = (left != '0);
    assign done = (left == CTW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left     <= '0;
            start_q  <= 1'b0;
            result_q <= '0;
        end else begin
            start_q <= go;
            if (go)        left <= LOAD;
            else if (busy) left <= left - 1'b1;
            if (done)      result_q <= result_in;
        end
    end
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
    import adc_if_pkg::*;
#(
    parameter int W            = 10,
    parameter int MAX_CLKS     = 16,
    parameter int SAMPLE_FIRST = 3,
    parameter int CS_STABLE    = 72,
    parameter int TMO_CYCLES   = 475,
    parameter int CONV_CYCLES  = 1050
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         io_clk,
    input  logic [W-1:0] conv_result,
    output logic         data_out,
    output logic         data_oe,
    output logic         sample_en,
    output logic         start_convert,
    output logic         busy,
    output logic         sync_err
);
    localparam int CNTW = $clog2(MAX_CLKS + 1);
    localparam int TW   = $clog2(TMO_CYCLES + 1);
    localparam logic [CNTW-1:0] LAST_BIT  = CNTW'(W - 1);
    localparam logic [CNTW-1:0] TENTH     = CNTW'(W);
    localparam logic [CNTW-1:0] FINAL     = CNTW'(MAX_CLKS);
    localparam logic [CNTW-1:0] FINAL_M1  = CNTW'(MAX_CLKS - 1);
    localparam logic [CNTW-1:0] SAMP_FROM = CNTW'(SAMPLE_FIRST);
    localparam logic [TW-1:0]   TMO_LIM   = TW'(TMO_CYCLES);

    // synchronized inputs and edges
    logic io_s, io_d, io_fall, io_rise;
    logic cs_s, cs_acc, cs_fall, cs_rise;

    adc_if_sync #(.STAGES(2), .RST_VAL(1'b0)) u_io_sync (
        .clk(clk), .rst_n(rst_n), .d(io_clk), .q(io_s)
    );
    adc_if_sync #(.STAGES(2), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
    );
    adc_if_csfilt #(.STABLE(CS_STABLE)) u_cs_filt (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s),
        .cs_acc(cs_acc), .acc_fall(cs_fall), .acc_rise(cs_rise)
    );

    assign io_fall = io_d && !io_s;
    assign io_rise = !io_d && io_s;

    // conversion engine timer
    logic         go, conv_done;
    logic [W-1:0] res_q;

    adc_if_conv #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk(clk), .rst_n(rst_n), .go(go), .result_in(conv_result),
        .busy(busy), .done(conv_done), .start_q(start_convert),
        .result_q(res_q)
    );

    // state machine
    fe_state_t       state, state_n;
    logic [CNTW-1:0] cnt, cnt_n;
    logic [W-1:0]    word, word_n;
    logic [TW-1:0]   tcnt, tcnt_n;
    logic            late;

    assign late = (tcnt == TMO_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            word  <= '0;
            tcnt  <= '0;
            io_d  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            word  <= word_n;
            tcnt  <= tcnt_n;
            io_d  <= io_s;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        word_n  = word;
        go      = 1'b0;
        tcnt_n  = tcnt;
        if (state == ST_TAIL && cnt == TENTH && !late)
            tcnt_n = tcnt + 1'b1;
        unique case (state)
            ST_IDLE: begin
                if (cs_fall) begin
                    state_n = ST_SHIFT;
                    cnt_n   = '0;
                    word_n  = res_q;
                end
            end
            ST_SHIFT: begin
                if (cs_rise) begin
                    state_n = ST_IDLE;
                end else if (io_fall) begin
                    cnt_n  = cnt + 1'b1;
                    word_n = {word[W-2:0], 1'b0};
                    if (cnt == LAST_BIT) begin
                        state_n = ST_TAIL;
                        go      = 1'b1;
                        tcnt_n  = '0;
                    end
                end
            end
            ST_TAIL: begin
                if (cs_rise) begin
                    state_n = ST_IDLE;
                end else if (conv_done && (cnt == TENTH || cnt == FINAL)) begin
                    state_n = ST_SHIFT;
                    cnt_n   = '0;
                    word_n  = conv_result;
                end else if (io_rise && cnt == TENTH && late && busy) begin
                    state_n = ST_LOST;
                end else if (io_fall && cnt != FINAL) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt == FINAL_M1 && !busy) begin
                        state_n = ST_SHIFT;
                        cnt_n   = '0;
                        word_n  = res_q;
                    end
                end
            end
            ST_LOST: begin
                if (cs_rise) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        data_out  = 1'b0;
        data_oe   = 1'b1;
        sample_en = 1'b0;
        sync_err  = 1'b0;
        unique case (state)
            ST_IDLE:  data_oe = 1'b0;
            ST_SHIFT: begin
                data_out  = word[W-1];
                sample_en = (cnt >= SAMP_FROM);
            end
            ST_TAIL:  data_out = 1'b0;
            ST_LOST:  sync_err = 1'b1;
            default:  data_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk (
    input logic clk,
    input logic rst_n,
    input logic data_out,
    input logic data_oe,
    input logic sample_en,
    input logic start_convert,
    input logic busy,
    input logic sync_err
);
    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_convert |-> busy);

    assert_start_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_convert |=> !start_convert);

    assert_tail_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_convert |-> (data_oe && !data_out && !sample_en));

    assert_sample_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> data_oe);

    assert_lost_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (data_oe && !data_out && !sample_en));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (!sample_en && !sync_err && !data_out));
endmodule

bind adc_serial_if adc_serial_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .data_out(data_out), .data_oe(data_oe),
    .sample_en(sample_en), .start_convert(start_convert), .busy(busy),
    .sync_err(sync_err)
);

// File: tb/tb_adc_serial_if.sv
module tb_adc_serial_if;
    localparam int STB  = 4;
    localparam int TMO  = 40;
    localparam int CONV = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       io_clk = 1'b0;
    logic [9:0] conv_result = '0;
    logic data_out, data_oe, sample_en, start_convert, busy, sync_err;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int starts_seen = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    adc_serial_if #(.CS_STABLE(STB), .TMO_CYCLES(TMO), .CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk),
        .conv_result(conv_result), .data_out(data_out), .data_oe(data_oe),
        .sample_en(sample_en), .start_convert(start_convert), .busy(busy),
        .sync_err(sync_err)
    );

    // behavioural reference: input history queues, integer counters
    bit io_hist[$];
    bit cs_hist[$];
    bit m_io_prev;
    bit m_cs_ok;
    int m_run;
    int m_mode;      // 0 idle, 1 shifting, 2 tail, 3 lost
    int m_edges;
    int m_bits;
    int m_wait;
    int m_conv_left;
    int m_saved;
    bit m_start;

    task automatic model_reset();
        io_hist = '{1'b0, 1'b0};
        cs_hist = '{1'b1, 1'b1};
        m_io_prev = 0; m_cs_ok = 1; m_run = 0; m_mode = 0; m_edges = 0;
        m_bits = 0; m_wait = 0; m_conv_left = 0; m_saved = 0; m_start = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit io_now, cs_now, fall, rise, csf, csr, fin, running, kick;
            int nmode, nedges, nbits, nwait;
            io_now  = io_hist[0];
            cs_now  = cs_hist[0];
            fall    = m_io_prev && !io_now;
            rise    = !m_io_prev && io_now;
            csf     = (cs_now != m_cs_ok) && (m_run == STB - 1) && m_cs_ok;
            csr     = (cs_now != m_cs_ok) && (m_run == STB - 1) && !m_cs_ok;
            fin     = (m_conv_left == 1);
            running = (m_conv_left != 0);
            kick    = 0;
            nmode = m_mode; nedges = m_edges; nbits = m_bits; nwait = m_wait;
            if (m_mode == 2 && m_edges == 10 && m_wait != TMO) nwait = m_wait + 1;
            if (m_mode == 0) begin
                if (csf) begin nmode = 1; nedges = 0; nbits = m_saved; end
            end else if (m_mode == 1) begin
                if (csr) nmode = 0;
                else if (fall) begin
                    nedges = m_edges + 1;
                    nbits = (m_bits * 2) % 1024;
                    if (m_edges == 9) begin nmode = 2; kick = 1; nwait = 0; end
                end
            end else if (m_mode == 2) begin
                if (csr) nmode = 0;
                else if (fin && (m_edges == 10 || m_edges == 16)) begin
                    nmode = 1; nedges = 0; nbits = int'(conv_result);
                end else if (rise && m_edges == 10 && m_wait == TMO && running) begin
                    nmode = 3;
                end else if (fall && m_edges != 16) begin
                    nedges = m_edges + 1;
                    if (m_edges == 15 && !running) begin
                        nmode = 1; nedges = 0; nbits = m_saved;
                    end
                end
            end else begin
                if (csr) nmode = 0;
            end
            m_mode = nmode; m_edges = nedges; m_bits = nbits; m_wait = nwait;
            if (fin) m_saved = int'(conv_result);
            m_start = kick;
            if (kick) m_conv_left = CONV;
            else if (running) m_conv_left = m_conv_left - 1;
            if (cs_now == m_cs_ok) m_run = 0;
            else if (m_run == STB - 1) begin m_cs_ok = cs_now; m_run = 0; end
            else m_run = m_run + 1;
            m_io_prev = io_now;
            void'(io_hist.pop_front());
            void'(cs_hist.pop_front());
            io_hist.push_back(io_clk);
            cs_hist.push_back(cs_n);
        end
    end

    task automatic cmp(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // cycle-by-cycle comparison, sampled at the falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done_flag) begin
            cmp("R3", "data_out", int'(data_out), (m_mode == 1) ? ((m_bits >> 9) & 1) : 0);
            cmp("R2", "data_oe", int'(data_oe), (m_mode != 0) ? 1 : 0);
            cmp("R5", "sample_en", int'(sample_en), (m_mode == 1 && m_edges >= 3) ? 1 : 0);
            cmp("R6", "start_convert", int'(start_convert), int'(m_start));
            cmp("R6", "busy", int'(busy), (m_conv_left != 0) ? 1 : 0);
            cmp("R7", "sync_err", int'(sync_err), (m_mode == 3) ? 1 : 0);
            if (start_convert) starts_seen++;
        end
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(int n, int h1, int h2, output logic [15:0] bits);
        bits = '0;
        for (int i = 0; i < n; i++) begin
            int h;
            bits[15-i] = data_out;
            h = (i < 10) ? h1 : h2;
            io_clk = 1'b1;
            wait_clk(h);
            io_clk = 1'b0;
            wait_clk(h);
        end
    endtask

    task automatic wait_idle_conv();
        for (int i = 0; i < 1000 && busy; i++) wait_clk(1);
        wait_clk(2);
    endtask

    initial begin
        logic [15:0] b;
        int s0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);
        // R1 reset state
        cmp("R1", "data_oe after reset", int'(data_oe), 0);
        cmp("R1", "busy after reset", int'(busy), 0);
        cmp("R1", "sync_err after reset", int'(sync_err), 0);
        cmp("R1", "sample_en after reset", int'(sample_en), 0);

        // R2 clocks with select high are ignored
        frame(12, 6, 6, b);
        cmp("R2", "busy after clocks with cs high", int'(busy), 0);
        cmp("R2", "oe with cs high", int'(data_oe), 0);

        // R8 short select glitch
        cs_n = 1'b0; wait_clk(2); cs_n = 1'b1; wait_clk(12);
        cmp("R8", "oe after short glitch", int'(data_oe), 0);

        // select toggled, 10 clocks: first returns reset value
        conv_result = 10'h2A5;
        cs_n = 1'b0; wait_clk(12);
        frame(10, 6, 6, b);
        cmp("R3", "first frame word", int'(b[15:6]), 0);
        cmp("R6", "busy after tenth clock", int'(busy), 1);
        cs_n = 1'b1; wait_clk(12);
        cmp("R11", "oe after select rise", int'(data_oe), 0);
        wait_idle_conv();
        conv_result = 10'h0FF;
        cs_n = 1'b0; wait_clk(12);
        frame(10, 6, 6, b);
        cmp("R3", "previous result shifted out", int'(b[15:6]), 'h2A5);
        cs_n = 1'b1; wait_clk(12);
        wait_idle_conv();

        // R6 truncated transfer starts nothing
        s0 = starts_seen;
        cs_n = 1'b0; wait_clk(12);
        frame(7, 6, 6, b);
        cs_n = 1'b1; wait_clk(20);
        cmp("R6", "starts after 7-clock transfer", starts_seen - s0, 0);
        cmp("R6", "busy after 7-clock transfer", int'(busy), 0);

        // R4 16-clock transfer with select toggled
        cs_n = 1'b0; wait_clk(12);
        frame(16, 6, 6, b);
        cmp("R3", "word in 16-clock transfer", int'(b[15:6]), 'h0FF);
        cmp("R4", "trailing bits", int'(b[5:0]), 0);
        cs_n = 1'b1; wait_clk(12);
        wait_idle_conv();

        // R9 held select, 10-clock transfers
        conv_result = 10'h3C3;
        cs_n = 1'b0; wait_clk(12);
        frame(10, 6, 6, b);
        cmp("R3", "held-select first word", int'(b[15:6]), 'h0FF);
        wait_idle_conv();
        cmp("R9", "oe after completion", int'(data_oe), 1);
        cmp("R9", "MSB after completion", int'(data_out), 1);
        conv_result = 10'h155;
        frame(10, 6, 6, b);
        cmp("R9", "word of held-select frame", int'(b[15:6]), 'h3C3);
        wait_idle_conv();

        // R10 held select, slow 16-clock transfer
        conv_result = 10'h2E7;
        frame(16, 6, 20, b);
        cmp("R10", "slow 16 word", int'(b[15:6]), 'h155);
        cmp("R4", "slow 16 trailing bits", int'(b[5:0]), 0);
        cmp("R10", "MSB after sixteenth edge", int'(data_out), 1);
        // R10 fast 16-clock transfer
        conv_result = 10'h09A;
        frame(16, 6, 6, b);
        cmp("R10", "fast 16 word", int'(b[15:6]), 'h2E7);
        wait_idle_conv();
        frame(10, 6, 6, b);
        cmp("R10", "word after fast 16", int'(b[15:6]), 'h09A);

        // R7 late eleventh clock
        wait_clk(60);
        io_clk = 1'b1; wait_clk(8);
        cmp("R7", "sync_err after late clock", int'(sync_err), 1);
        cmp("R7", "data_out while lost", int'(data_out), 0);
        io_clk = 1'b0; wait_clk(6);
        cs_n = 1'b1; wait_clk(12);
        cmp("R11", "sync_err cleared by select rise", int'(sync_err), 0);
        cmp("R11", "conversion continues after select rise", int'(busy), 1);
        wait_idle_conv();
        wait_clk(4);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule